// File: doc/BRIEF.md
# Two-Wire Clock-Enable Control Slave

This block is a two-wire serial slave that owns a small file of control registers. The registers hold one enable bit for each of eighteen fanned-out clock outputs. The block runs on a fast system clock and treats SCL and SDA as ordinary inputs. It synchronises both lines and derives bit strobes and START/STOP conditions from their edges. It answers by pulling SDA low through an open-drain style output.

The device address the master sends also selects the protocol. The two addresses of the form 1011x00 (bit 2 is a don't-care) select register mode. In register mode the first written byte sets a register pointer. Data bytes then go to the pointed register, and the pointer advances after each one. A read after a repeated START streams bytes out from the pointer. Address 1101001 selects block mode. In block mode the pointer is forced to register 0 and the command byte must be zero. On a write, a byte-count byte is taken and then ignored. On a read, the slave first sends a count of 3 and then the registers from 0 upward. In both modes the pointer wraps from the last register back to register 0.

Each register takes its new value at the moment the slave acknowledges that byte. A byte cut short by STOP or by a repeated START leaves every register unchanged.

Top module: `twowire_clkctl_slave`

## Requirements
- R1: After reset every output of `clk_en_o` is 1, and register 2 reads back as 0xC0.
- R2: The slave acknowledges the address byte only for addresses 0x58, 0x5C and 0x69 (7-bit). For any other address it never pulls SDA for the rest of that transfer.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START seen in the middle of a byte restarts address reception. SDA is sampled on the rising edge of SCL, and the slave changes its SDA drive only while SCL is low.
- R4: In register mode the byte after a write address becomes the pointer. Each following data byte is stored at the pointer, and the pointer then advances 0→1→2→0.
- R5: A written register shows on `clk_en_o` once its acknowledge bit has been driven, before any STOP.
- R6: A data byte ended by STOP or by a repeated START before its acknowledge changes no register.
- R7: After a repeated START with a read address, the slave sends bytes starting at the pointer and advances the pointer with wrap after each byte. After the master NACKs, the slave releases SDA.
- R8: In block mode a write starts at register 0, whatever the pointer held. A command byte of 0x00 is acknowledged, and so is the byte-count byte, whose value is ignored. A non-zero command byte is NACKed, and the data bytes after it are NACKed and not stored.
- R9: A block-mode read (command 0x00, repeated START, read address) returns 0x03 and then registers 0, 1, 2.
- R10: Register 0 bit k drives output k, and register 1 bit k drives output 8+k. Register 2 bits 7 and 6 drive outputs 17 and 16. Register 2 bits 5..0 ignore writes and read as 0.
- R11: In register mode a pointer byte of 3 or more is NACKed. The data bytes after it are NACKed and not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired value) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| clk_en_o | output | 18 | Per-output clock enable vector |

## Verification
The assertions assume a well-behaved master. It keeps SDA steady while SCL is high, except for deliberate START and STOP conditions. Each SCL high and low phase is longer than the synchroniser latency, so every line change is seen in order. The master never issues START or STOP while the slave is pulling SDA. The bench holds every SCL phase for six system clocks and moves SDA only in the middle of a low phase. It issues STOP only after an acknowledge slot has ended or a NACK has been given.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEVADR, ST_REGADR, ST_BCNT, ST_WDATA, ST_RDATA, ST_RACK
  } bus_st_e;

  localparam logic [6:0] REG_ADDR_BASE = 7'b1011000;
  localparam logic [6:0] REG_ADDR_MASK = 7'b1111011;
  localparam logic [6:0] BLK_ADDR      = 7'b1101001;
endpackage

// File: rtl/twc_line_sync.sv
module twc_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/twc_bus_events.sv
module twc_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/twc_regfile.sv
module twc_regfile #(
  parameter int NUM_OUT = 18,
  localparam int NREG   = (NUM_OUT + 7) / 8,
  localparam int IW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IW-1:0]      rd_idx,
  output logic [7:0]         rd_data,
  output logic [NUM_OUT-1:0] outs
);
  function automatic logic [7:0] live_mask(input int i);
    int v;
    v = NUM_OUT - 8 * i;
    if (v > 8) v = 8;
    return ~(8'hFF >> v);
  endfunction

  localparam logic [7:0] LAST_MSK = live_mask(NREG - 1);

  logic [7:0] rg [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rg[i] <= live_mask(i);
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (wr_idx == IW'(i)) rg[i] <= wr_data & live_mask(i);
    end
  end

  assign rd_data = ({1'b0, rd_idx} < (IW+1)'(NREG)) ? rg[rd_idx] : 8'h00;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int V = (NUM_OUT - 8 * g > 8) ? 8 : NUM_OUT - 8 * g;
    for (genvar k = 0; k < 8; k++) begin : g_bit
      if (k < V) begin : g_map
        assign outs[8*g+k] = rg[g][8-V+k];
      end
    end
  end

  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(NREG-1)) |=> ((rg[NREG-1] & ~LAST_MSK) == 8'h00)); // R10
endmodule

// File: rtl/twowire_clkctl_slave.sv
module twowire_clkctl_slave
  import twc_pkg::*;
#(
  parameter int NUM_OUT     = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [NUM_OUT-1:0] clk_en_o
);
  localparam int NREG = (NUM_OUT + 7) / 8;
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1;

  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_c, stop_c;

  twc_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines_s));
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  twc_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c));

  bus_st_e     st, st_nxt;
  logic        ack_slot, ack_drv, smb_mode, rd_nack, cnt_pend;
  logic [3:0]  nbits;
  logic [7:0]  rx_sr, tx_sr;
  logic [IW-1:0] ptr, wr_idx;
  logic        wr_en;
  logic [7:0]  wr_data, rd_data;
  logic        is_reg, is_blk;

  function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
    return (p == IW'(NREG-1)) ? '0 : p + IW'(1);
  endfunction

  twc_regfile #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(ptr), .rd_data(rd_data), .outs(clk_en_o));

  assign is_reg = (rx_sr[7:1] & REG_ADDR_MASK) == REG_ADDR_BASE;
  assign is_blk = rx_sr[7:1] == BLK_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  st_nxt <= ST_IDLE;
      ack_slot <= 1'b0; ack_drv <= 1'b0; smb_mode <= 1'b0;
      rd_nack <= 1'b0; cnt_pend <= 1'b0; nbits <= '0;
      rx_sr <= '0; tx_sr <= 8'hFF; ptr <= '0;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_c) begin
        st <= ST_IDLE; ack_slot <= 1'b0; ack_drv <= 1'b0;
      end else if (start_c) begin
        st <= ST_DEVADR; ack_slot <= 1'b0; ack_drv <= 1'b0; nbits <= '0;
      end else begin
        case (st)
          ST_IDLE: ;
          ST_RDATA: begin
            if (scl_rise) nbits <= nbits + 4'd1;
            else if (scl_fall) begin
              if (nbits == 4'd8) st <= ST_RACK;
              else tx_sr <= {tx_sr[6:0], 1'b0};
            end
          end
          ST_RACK: begin
            if (scl_rise) rd_nack <= sda_s;
            else if (scl_fall) begin
              if (rd_nack) st <= ST_IDLE;
              else begin
                st <= ST_RDATA; nbits <= '0;
                if (cnt_pend) begin tx_sr <= 8'(NREG); cnt_pend <= 1'b0; end
                else begin tx_sr <= rd_data; ptr <= ptr_inc(ptr); end
              end
            end
          end
          default: begin
            if (!ack_slot) begin
              if (scl_rise) begin
                rx_sr <= {rx_sr[6:0], sda_s};
                nbits <= nbits + 4'd1;
              end else if (scl_fall && nbits == 4'd8) begin
                nbits <= '0;
                ack_slot <= 1'b1;
                case (st)
                  ST_DEVADR: begin
                    ack_drv <= is_reg | is_blk;
                    smb_mode <= is_blk;
                    if (is_blk) ptr <= '0;
                    cnt_pend <= is_blk & rx_sr[0];
                    if (!(is_reg | is_blk)) st_nxt <= ST_IDLE;
                    else st_nxt <= rx_sr[0] ? ST_RDATA : ST_REGADR;
                  end
                  ST_REGADR: begin
                    if (smb_mode) begin
                      ack_drv <= (rx_sr == 8'h00);
                      st_nxt <= (rx_sr == 8'h00) ? ST_BCNT : ST_IDLE;
                    end else begin
                      ack_drv <= (rx_sr < 8'(NREG));
                      st_nxt <= (rx_sr < 8'(NREG)) ? ST_WDATA : ST_IDLE;
                      if (rx_sr < 8'(NREG)) ptr <= rx_sr[IW-1:0];
                    end
                  end
                  ST_BCNT: begin
                    ack_drv <= 1'b1;
                    st_nxt <= ST_WDATA;
                  end
                  default: begin
                    ack_drv <= 1'b1;
                    wr_en <= 1'b1; wr_idx <= ptr; wr_data <= rx_sr;
                    ptr <= ptr_inc(ptr);
                    st_nxt <= ST_WDATA;
                  end
                endcase
              end
            end else if (scl_fall) begin
              ack_slot <= 1'b0;
              ack_drv <= 1'b0;
              st <= st_nxt;
              if (st_nxt == ST_RDATA) begin
                if (cnt_pend) begin tx_sr <= 8'(NREG); cnt_pend <= 1'b0; end
                else begin tx_sr <= rd_data; ptr <= ptr_inc(ptr); end
              end
            end
          end
        endcase
      end
    end
  end

  assign sda_pull_o = ack_drv | ((st == ST_RDATA) & ~tx_sr[7]);

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull_o) && !$past(start_c || stop_c)) |-> !scl_s); // R3
  AST_COMMIT_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ack_drv); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull_o); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(NREG-1)) |-> (ptr == '0)); // R4
  AST_NACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && scl_fall && rd_nack && !start_c && !stop_c) |=> !sda_pull_o); // R7
  AST_BLK_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (smb_mode && st == ST_REGADR && ack_slot && ack_drv) |-> (rx_sr == 8'h00)); // R8
endmodule

// File: tb/sim_twowire_clkctl_slave.sv
module sim_twowire_clkctl_slave;
  localparam int H = 6;
  localparam logic [6:0] AREG0 = 7'h58, AREG1 = 7'h5C, ABLK = 7'h69;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic pull;
  logic sda_w;
  logic [17:0] en;
  assign sda_w = m_sda & ~pull;

  twowire_clkctl_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_w),
    .sda_pull_o(pull), .clk_en_o(en));

  int nvec = 0, nbad = 0;
  logic [7:0] mdl [3];

  function automatic logic [7:0] msk(input int i);
    return (i == 2) ? ~(8'hFF >> 2) : 8'hFF;
  endfunction

  function automatic logic [17:0] mvec();
    return {mdl[2][7:6], mdl[1], mdl[0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(H); m_scl = 1'b1; hold(H);
    m_sda = 1'b0; hold(H); m_scl = 1'b0; hold(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(H); m_scl = 1'b1; hold(H); m_sda = 1'b1; hold(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; hold(H); m_scl = 1'b1; hold(H); m_scl = 1'b0; hold(H);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; hold(H); m_scl = 1'b1; hold(H/2);
    b = sda_w; hold(H - H/2); m_scl = 1'b0; hold(H);
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) put_bit(d[i]);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    send_bits(d, 8);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~mack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [17:0] snap;
    mdl[0] = 8'hFF; mdl[1] = 8'hFF; mdl[2] = 8'hC0;
    hold(5); rst_n = 1'b1; hold(5);
    chk("R1 reset enables", en, 18'h3FFFF);
    chk("R1 idle no pull", pull, 0);

    // R1/R10: register 2 reads as 0xC0 after reset
    bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'd2, ack);
    bus_start(); send_byte({AREG0, 1'b1}, ack); recv_byte(1'b0, d); bus_stop();
    chk("R1 reg2 readback", d, 8'hC0);

    // R2: address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start(); send_byte({7'(a), 1'b0}, ack); bus_stop();
      chk("R2 address ack", ack, (((a & 7'h7B) == 7'h58) || (a == 7'h69)) ? 1 : 0);
    end

    // R4/R5: register-mode writes, every start pointer and lengths 1..4
    for (int p = 0; p < 3; p++) begin
      for (int len = 1; len <= 4; len++) begin
        int q;
        bus_start(); send_byte({(len % 2 == 1) ? AREG1 : AREG0, 1'b0}, ack);
        chk("R4 addr ack", ack, 1);
        send_byte(8'(p), ack); chk("R4 ptr ack", ack, 1);
        q = p;
        for (int j = 0; j < len; j++) begin
          d = 8'((p * 37 + len * 11 + j * 53) ^ 8'h5A);
          send_byte(d, ack);
          chk("R4 data ack", ack, 1);
          mdl[q] = d & msk(q);
          q = (q + 1) % 3;
          chk("R5 committed before stop", en, mvec());
        end
        bus_stop();
      end
    end

    // R7: register-mode sequential reads with wrap
    for (int p = 0; p < 3; p++) begin
      for (int len = 1; len <= 5; len++) begin
        bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'(p), ack);
        bus_start(); send_byte({AREG0, 1'b1}, ack);
        chk("R7 read addr ack", ack, 1);
        for (int j = 0; j < len; j++) begin
          recv_byte(j != len - 1, d);
          chk("R7 read data", d, mdl[(p + j) % 3]);
        end
        chk("R7 released after nack", pull, 0);
        bus_stop();
      end
    end

    // R6: data byte cut by STOP
    snap = en;
    bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'd0, ack);
    send_bits(~mdl[0], 5); bus_stop();
    chk("R6 stop mid byte", en, snap);

    // R6/R3: data byte cut by repeated START, then restart works
    bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'd1, ack);
    send_bits(~mdl[1], 7);
    bus_start(); send_byte({AREG0, 1'b0}, ack);
    chk("R3 restart address ack", ack, 1);
    send_byte(8'd1, ack); bus_stop();
    chk("R6 restart mid byte", en, snap);

    // R3: START inside an address byte restarts reception
    bus_start(); send_bits(8'hFF, 3);
    bus_start(); send_byte({AREG1, 1'b0}, ack);
    chk("R3 start mid address", ack, 1);
    bus_stop();

    // R11: pointer out of range
    bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'd3, ack);
    chk("R11 ptr 3 nack", ack, 0);
    send_byte(8'h00, ack); chk("R11 data after bad ptr nack", ack, 0);
    bus_stop();
    chk("R11 no register change", en, snap);

    // R8: block write ignores the stale pointer, count and starts at 0
    bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'd2, ack); bus_stop();
    bus_start(); send_byte({ABLK, 1'b0}, ack); chk("R8 blk addr ack", ack, 1);
    send_byte(8'h00, ack); chk("R8 cmd zero ack", ack, 1);
    send_byte(8'd7, ack); chk("R8 count ack", ack, 1);
    for (int j = 0; j < 4; j++) begin
      d = 8'(8'hA3 + j * 29);
      send_byte(d, ack); chk("R8 blk data ack", ack, 1);
      mdl[j % 3] = d & msk(j % 3);
    end
    bus_stop();
    chk("R8 blk write result", en, mvec());
    snap = en;
    bus_start(); send_byte({ABLK, 1'b0}, ack); send_byte(8'h01, ack);
    chk("R8 nonzero cmd nack", ack, 0);
    send_byte(8'h00, ack); chk("R8 data after bad cmd nack", ack, 0);
    bus_stop();
    chk("R8 bad cmd no change", en, snap);

    // R9: block read
    bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'd1, ack); bus_stop();
    bus_start(); send_byte({ABLK, 1'b0}, ack); send_byte(8'h00, ack);
    bus_start(); send_byte({ABLK, 1'b1}, ack); chk("R9 blk read addr ack", ack, 1);
    recv_byte(1'b1, d); chk("R9 count byte", d, 8'h03);
    for (int j = 0; j < 3; j++) begin
      recv_byte(j != 2, d); chk("R9 blk data", d, mdl[j]);
    end
    bus_stop();

    // R10: walking one over register 1, and the live bits of register 2
    for (int k = 0; k < 8; k++) begin
      bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'd1, ack);
      send_byte(8'(1 << k), ack); bus_stop();
      mdl[1] = 8'(1 << k);
      chk("R10 byte1 mapping", en, mvec());
    end
    bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'd2, ack);
    send_byte(8'h7F, ack); bus_stop();
    mdl[2] = 8'h7F & msk(2);
    chk("R10 out17 off out16 on", en[17:16], 2'b01);
    bus_start(); send_byte({AREG0, 1'b0}, ack); send_byte(8'd2, ack);
    bus_start(); send_byte({AREG0, 1'b1}, ack); recv_byte(1'b0, d); bus_stop();
    chk("R10 reserved read zero", d, 8'h40);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule